// File: doc/BRIEF.md
# Quadword Staging FIFO

This block buffers up to sixteen 128-bit quadwords between a DMA source and a downstream packet consumer. The source offers a burst of N quadwords in one cycle, presenting all N slots on a wide data bus. The FIFO takes as many as fit in the free space and reports the accepted amount on the next cycle. The source keeps the rest for a later attempt.

When the consumer's path is available and the FIFO holds data, the block presents every held quadword to the consumer at once, oldest in slot 0. The consumer answers with a ready strobe and a taken count K. It may accept only part of what is offered. The entries it did not take slide to the front in their original order, so the oldest survivor is again in slot 0 on the next cycle.

A live occupancy count and a two-bit fullness code are kept in registers so that a status register can read them directly. If a write and a drain arrive in the same cycle, the drain is applied first and the write is accepted into the space that the drain freed.

Top module: `qsf_top`

## Requirements
- R1: The store holds at most 16 quadwords of 128 bits, and the occupancy output never exceeds 16.
- R2: A write of N quadwords accepts min(N, 16 - occupancy after any same-cycle drain). The accepted amount appears on `wr_acc` one cycle after the request and is 0 in cycles with no write. A write offered to a full FIFO with no drain is accepted as 0.
- R3: `fill_cnt` equals the number of quadwords held. A cycle with neither a write nor a completed drain leaves it unchanged.
- R4: `fill_code` is 2'b01 (EMPTY) at occupancy 0, 2'b10 (FULL) at occupancy 15 or 16, and 2'b00 (NORMAL) otherwise. It changes in the same cycle as `fill_cnt`.
- R5: `dr_valid` is high only when the FIFO is non-empty and `path_ok` is high. When `dr_valid` is low, `dr_ready` and `dr_taken` are ignored and nothing is removed.
- R6: A drain that takes K quadwords with K below the occupancy removes the K oldest. The survivors move to the front in order and the count becomes occupancy-K. `dr_data` holds the oldest entry in bits [127:0] and slot i in bits [128*i+127 : 128*i].
- R7: A drain with K equal to or greater than the occupancy empties the FIFO. K is clamped to the occupancy.
- R8: When a write and a drain complete in the same cycle, the drain is applied first. The written quadwords land directly behind the survivors, in burst order.
- R9: Synchronous reset clears all stored quadwords to zero, sets the occupancy to 0 and sets the code to EMPTY.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_valid | input | 1 | Burst write request |
| wr_len | input | 8 | Number of quadwords offered, N |
| wr_data | input | 2048 | Offered quadwords, slot j at bits [128*j +: 128] |
| wr_acc | output | 5 | Quadwords accepted by the previous cycle's write |
| path_ok | input | 1 | Downstream path available |
| dr_valid | output | 1 | Held quadwords are offered to the consumer |
| dr_data | output | 2048 | Held quadwords, oldest in slot 0 |
| dr_ready | input | 1 | Consumer completes a drain this cycle |
| dr_taken | input | 5 | Quadwords the consumer took, K |
| fill_cnt | output | 5 | Current occupancy |
| fill_code | output | 2 | Fullness code: 00 NORMAL, 01 EMPTY, 10 FULL |

## Verification
A burst write and a consumer drain can complete in the same clock edge. The bench provokes this by asserting `wr_valid` together with `dr_ready` while `path_ok` is high. It does so when the FIFO is full, so that the accepted amount depends on the space the drain frees. It also does so at partial occupancy, so that the new quadwords must land directly behind compacted survivors. A queue-based model applies the drain first, then the write. On every clock it compares the occupancy, the code, the accepted count and every valid slot of `dr_data` against the model.

// File: rtl/qsf_pkg.sv
package qsf_pkg;
  typedef enum logic [1:0] {
    FILL_NORMAL = 2'b00,
    FILL_EMPTY  = 2'b01,
    FILL_FULL   = 2'b10
  } fill_e;
endpackage

// File: rtl/qsf_ctrl.sv
module qsf_ctrl #(
  parameter int DEPTH = 16,
  parameter int CNT_W = 5,
  parameter int LEN_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_valid,
  input  logic [LEN_W-1:0] wr_len,
  input  logic             dr_fire,
  input  logic [CNT_W-1:0] dr_taken,
  output logic [CNT_W-1:0] take_k,
  output logic [CNT_W-1:0] base,
  output logic [CNT_W-1:0] put_n,
  output logic [CNT_W-1:0] cnt_nxt,
  output logic [CNT_W-1:0] cnt,
  output logic [CNT_W-1:0] wr_acc
);
  localparam logic [CNT_W-1:0] DEPTH_C = CNT_W'(DEPTH);

  logic [CNT_W-1:0] room;

  always_comb begin
    // drain is resolved first, the write then sees the freed space
    take_k = '0;
    if (dr_fire) take_k = (dr_taken > cnt) ? cnt : dr_taken;
    base = cnt - take_k;
    room = DEPTH_C - base;
    put_n = '0;
    if (wr_valid) begin
      if (int'(wr_len) > int'(room)) put_n = room;
      else                           put_n = CNT_W'(wr_len);
    end
    cnt_nxt = base + put_n;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt    <= '0;
      wr_acc <= '0;
    end else begin
      cnt    <= cnt_nxt;
      wr_acc <= put_n;
    end
  end

  assert_cnt_bound_R1: assert property (@(posedge clk) disable iff (rst)
    cnt <= DEPTH_C);

  assert_full_refuse_R2: assert property (@(posedge clk) disable iff (rst)
    ($past(cnt) == DEPTH_C && !$past(dr_fire)) |-> wr_acc == '0);

  assert_idle_hold_R3: assert property (@(posedge clk) disable iff (rst)
    (!$past(wr_valid) && !$past(dr_fire)) |-> cnt == $past(cnt));

  assert_drain_empty_R7: assert property (@(posedge clk) disable iff (rst)
    ($past(dr_fire) && !$past(wr_valid) && ($past(dr_taken) >= $past(cnt)))
      |-> cnt == '0);
endmodule

// File: rtl/qsf_store.sv
module qsf_store #(
  parameter int DEPTH = 16,
  parameter int QW_W  = 128,
  parameter int CNT_W = 5
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic [CNT_W-1:0]      take_k,
  input  logic [CNT_W-1:0]      base,
  input  logic [CNT_W-1:0]      put_n,
  input  logic [DEPTH*QW_W-1:0] wr_data,
  output logic [DEPTH*QW_W-1:0] rd_flat
);
  logic [QW_W-1:0] mem [DEPTH];
  logic [QW_W-1:0] nxt [DEPTH];

  always_comb begin
    for (int i = 0; i < DEPTH; i++) begin
      nxt[i] = mem[i];
      if (i < int'(base)) begin
        // survivor i came from position i+K
        if (i + int'(take_k) < DEPTH) nxt[i] = mem[i + int'(take_k)];
      end else if (i < int'(base) + int'(put_n)) begin
        nxt[i] = wr_data[(i - int'(base))*QW_W +: QW_W];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
    end else begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= nxt[i];
    end
  end

  genvar g;
  generate
    for (g = 0; g < DEPTH; g++) begin : g_out
      assign rd_flat[g*QW_W +: QW_W] = mem[g];
    end
  endgenerate

  assert_clear_R9: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (mem[0] == '0 || $past(put_n) != '0));
endmodule

// File: rtl/qsf_status.sv
module qsf_status
  import qsf_pkg::*;
#(
  parameter int CNT_W   = 5,
  parameter int FULL_AT = 15
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [CNT_W-1:0] cnt_nxt,
  output logic [1:0]       code
);
  fill_e code_nxt;

  always_comb begin
    if (int'(cnt_nxt) >= FULL_AT) code_nxt = FILL_FULL;
    else if (cnt_nxt == '0)       code_nxt = FILL_EMPTY;
    else                          code_nxt = FILL_NORMAL;
  end

  always_ff @(posedge clk) begin
    if (rst) code <= FILL_EMPTY;
    else     code <= code_nxt;
  end
endmodule

// File: rtl/qsf_top.sv
module qsf_top
  import qsf_pkg::*;
#(
  parameter int DEPTH   = 16,
  parameter int QW_W    = 128,
  parameter int LEN_W   = 8,
  parameter int FULL_AT = 15,
  localparam int CNT_W  = $clog2(DEPTH + 1),
  localparam int BUS_W  = DEPTH * QW_W
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_valid,
  input  logic [LEN_W-1:0] wr_len,
  input  logic [BUS_W-1:0] wr_data,
  output logic [CNT_W-1:0] wr_acc,
  input  logic             path_ok,
  output logic             dr_valid,
  output logic [BUS_W-1:0] dr_data,
  input  logic             dr_ready,
  input  logic [CNT_W-1:0] dr_taken,
  output logic [CNT_W-1:0] fill_cnt,
  output logic [1:0]       fill_code
);
  localparam logic [CNT_W-1:0] DEPTH_C = CNT_W'(DEPTH);

  logic             dr_fire;
  logic [CNT_W-1:0] take_k, base, put_n, cnt_nxt;

  assign dr_valid = (fill_cnt != '0) && path_ok;
  assign dr_fire  = dr_valid && dr_ready;

  qsf_ctrl #(.DEPTH(DEPTH), .CNT_W(CNT_W), .LEN_W(LEN_W)) ctrl_i (
    .clk(clk), .rst(rst), .wr_valid(wr_valid), .wr_len(wr_len),
    .dr_fire(dr_fire), .dr_taken(dr_taken), .take_k(take_k), .base(base),
    .put_n(put_n), .cnt_nxt(cnt_nxt), .cnt(fill_cnt), .wr_acc(wr_acc)
  );

  qsf_store #(.DEPTH(DEPTH), .QW_W(QW_W), .CNT_W(CNT_W)) store_i (
    .clk(clk), .rst(rst), .take_k(take_k), .base(base), .put_n(put_n),
    .wr_data(wr_data), .rd_flat(dr_data)
  );

  qsf_status #(.CNT_W(CNT_W), .FULL_AT(FULL_AT)) status_i (
    .clk(clk), .rst(rst), .cnt_nxt(cnt_nxt), .code(fill_code)
  );

  assert_code_match_R4: assert property (@(posedge clk) disable iff (rst)
    (fill_code == FILL_EMPTY)  == (fill_cnt == '0) &&
    (fill_code == FILL_FULL)   == (int'(fill_cnt) >= FULL_AT));

  assert_no_drain_R5: assert property (@(posedge clk) disable iff (rst)
    (!$past(path_ok) && !$past(wr_valid)) |-> fill_cnt == $past(fill_cnt));

  assert_drain_first_R8: assert property (@(posedge clk) disable iff (rst)
    ($past(dr_fire) && $past(wr_valid) && $past(wr_len) != '0 &&
     $past(dr_taken) != '0 && $past(fill_cnt) == DEPTH_C) |-> wr_acc != '0);
endmodule

// File: tb/qsf_top_tb_top.sv
`timescale 1ns/1ps
module qsf_top_tb_top;
  localparam int DEPTH = 16;
  localparam int QW_W  = 128;
  localparam int LEN_W = 8;
  localparam int CNT_W = 5;
  localparam int BUS_W = DEPTH * QW_W;

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic             wr_valid = 1'b0;
  logic [LEN_W-1:0] wr_len = '0;
  logic [BUS_W-1:0] wr_data = '0;
  logic [CNT_W-1:0] wr_acc;
  logic             path_ok = 1'b0;
  logic             dr_valid;
  logic [BUS_W-1:0] dr_data;
  logic             dr_ready = 1'b0;
  logic [CNT_W-1:0] dr_taken = '0;
  logic [CNT_W-1:0] fill_cnt;
  logic [1:0]       fill_code;

  int total = 0;
  int bad = 0;
  bit done = 0;
  int seq = 1;
  logic [QW_W-1:0] model_q [$];

  always #2 clk = ~clk;

  qsf_top dut_i (
    .clk(clk), .rst(rst), .wr_valid(wr_valid), .wr_len(wr_len),
    .wr_data(wr_data), .wr_acc(wr_acc), .path_ok(path_ok),
    .dr_valid(dr_valid), .dr_data(dr_data), .dr_ready(dr_ready),
    .dr_taken(dr_taken), .fill_cnt(fill_cnt), .fill_code(fill_code)
  );

  function automatic logic [QW_W-1:0] mk(int s);
    return {32'hC0DE0000 + 32'(s), 32'(s * 7), ~32'(s), 32'(s)};
  endfunction

  function automatic logic [1:0] exp_code(int n);
    if (n >= 15) return 2'b10;
    if (n == 0)  return 2'b01;
    return 2'b00;
  endfunction

  task automatic chk(bit ok, string req, string what, logic [QW_W-1:0] act,
                     logic [QW_W-1:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic compare(int acc_exp, bit pok, string tag);
    chk(int'(fill_cnt) == model_q.size(), "R3", {tag, " count"},
        QW_W'(fill_cnt), QW_W'(model_q.size()));
    chk(fill_code == exp_code(model_q.size()), "R4", {tag, " code"},
        QW_W'(fill_code), QW_W'(exp_code(model_q.size())));
    chk(int'(wr_acc) == acc_exp, "R2", {tag, " accepted"},
        QW_W'(wr_acc), QW_W'(acc_exp));
    chk(dr_valid == (model_q.size() > 0 && pok), "R5", {tag, " offer"},
        QW_W'(dr_valid), QW_W'(model_q.size() > 0 && pok));
    for (int i = 0; i < model_q.size(); i++)
      chk(dr_data[i*QW_W +: QW_W] == model_q[i], "R6", {tag, " slot data"},
          dr_data[i*QW_W +: QW_W], model_q[i]);
  endtask

  // one clock: drive at negedge, model drain first then write (R8)
  task automatic step(bit wv, int len, bit rdy, int taken, bit pok, string tag);
    int acc;
    int k;
    @(negedge clk);
    wr_valid = wv;
    wr_len   = LEN_W'(len);
    for (int j = 0; j < DEPTH; j++) wr_data[j*QW_W +: QW_W] = mk(seq + j);
    dr_ready = rdy;
    dr_taken = CNT_W'(taken);
    path_ok  = pok;
    if (model_q.size() > 0 && pok && rdy) begin
      k = (taken > model_q.size()) ? model_q.size() : taken;
      for (int i = 0; i < k; i++) void'(model_q.pop_front());
    end
    acc = 0;
    if (wv) begin
      acc = DEPTH - model_q.size();
      if (len < acc) acc = len;
      for (int j = 0; j < acc; j++) model_q.push_back(mk(seq + j));
      seq += acc;
    end
    @(posedge clk);
    #1;
    compare(acc, pok, tag);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1;
    wr_valid = 1'b0;
    dr_ready = 1'b0;
    path_ok = 1'b0;
    repeat (3) @(posedge clk);
    #1;
    model_q.delete();
    chk(fill_cnt == '0, "R9", "reset count", QW_W'(fill_cnt), '0);
    chk(fill_code == 2'b01, "R9", "reset code", QW_W'(fill_code), QW_W'(2'b01));
    for (int i = 0; i < DEPTH; i++)
      chk(dr_data[i*QW_W +: QW_W] == '0, "R9", "reset data",
          dr_data[i*QW_W +: QW_W], '0);
    @(negedge clk);
    rst = 1'b0;
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      bad++;
      $display("FAIL R3 watchdog actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    int unsigned lf;
    do_reset();
    step(0, 0, 0, 0, 0, "R3 idle");
    step(1, 5, 0, 0, 0, "R2 write 5");
    step(1, 12, 0, 0, 0, "R2 partial accept to 16");
    step(1, 3, 0, 0, 1, "R2 full refuse");
    step(0, 0, 1, 4, 0, "R5 path blocked");
    step(0, 0, 1, 6, 1, "R6 partial drain");
    step(1, 0, 0, 0, 1, "R3 zero write");
    step(1, 20, 0, 0, 0, "R1 refill to 16");
    step(1, 9, 1, 3, 1, "R8 full with drain");
    step(1, 2, 1, 5, 1, "R8 mid with drain");
    step(0, 0, 1, 20, 1, "R7 over-take empties");
    step(0, 0, 1, 3, 1, "R5 empty drain");
    step(1, 15, 0, 0, 1, "R4 fifteen full");
    step(0, 0, 1, 1, 1, "R4 fourteen normal");
    step(1, 1, 1, 14, 1, "R7 exact take with write");
    step(0, 0, 1, 1, 1, "R7 exact take");
    lf = 32'h1234_5678;
    for (int n = 0; n < 300; n++) begin
      lf = lf * 1103515245 + 12345;
      step(lf[20], int'(lf[27:23]) % 19, lf[21], int'(lf[14:10]) % 18,
           lf[22] | lf[19], "R6 mixed");
    end
    step(1, 16, 0, 0, 0, "R1 fill before reset");
    do_reset();
    step(0, 0, 0, 0, 1, "R9 after reset");
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule